// File: doc/BRIEF.md
# Upstream Grant-to-Instruction Scanner

This block turns a list of upstream transmission grants into a program of memory-fetch instructions. Each grant names a traffic identifier and a byte budget. The block resolves the identifier to one of its internal queues through an external lookup. It then walks that queue's frame index, which an ingress stage fills with the address and length of every stored frame. Whole frames are packed until the next one would overrun the budget, and one header instruction plus one payload instruction is written for each frame taken. The leftover budget becomes an idle fill instruction.

A playback engine later reads the instruction memory and streams the described byte runs in real time. Only addresses and lengths are handled here, so payload is never copied into a staging buffer. Frames that are not taken stay at the head of their queue for a later scan. A scan is started with a one-cycle `start_i` pulse. The block answers with a one-cycle `done_o` pulse, and at that point the instruction count and the error flag are valid.

Top module: `bwmap_scanner`

## Requirements
- R1: While `rst_ni` is low and after it is released, `done_o`, `error_o` and `imem_we_o` are 0 and `instr_count_o` is 0.
- R2: For each grant, the identifier is shown on `lut_id_o` and the returned queue select picks which queue's frame index is read. The index is read at that queue's own head slot.
- R3: A queued frame whose length plus `HDR_BYTES` fits in the remaining budget is taken. It produces two writes in consecutive cycles to consecutive instruction addresses: first a header word (kind 0, frame address, length `HDR_BYTES`, repeat 0), then a payload word (kind 1, frame address, frame length, repeat 0). The word layout is kind[35:34], scramble[33], repeat[32], address[31:16], length[15:0].
- R4: A frame that would overrun the remaining budget is not taken. It stays at the head of its queue, and the next grant to that queue starts with it.
- R5: A leftover budget of at least `HDR_BYTES` is written as one idle word: kind 2, address 0, length equal to the leftover, repeat 1.
- R6: A leftover between 1 and `HDR_BYTES`-1 is merged into the most recent idle word written since `start_i`. That word is rewritten at its own address with the leftover added to its length. The instruction count does not change.
- R7: A short leftover with no earlier idle word since `start_i` sets `error_o` and writes nothing. `error_o` then holds until the next `start_i`.
- R8: The scramble bit of every word written for a grant equals that grant's `alloc_scr_i`. A merge rewrite keeps the scramble bit of the word it extends.
- R9: `done_o` is high for exactly one cycle, the cycle after the last grant's final scan step, or the cycle after `start_i` when `alloc_num_i` is 0. At that point `instr_count_o` equals the number of distinct instruction addresses written.
- R10: A grant with zero budget writes nothing and costs three cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a scan (accepted when idle) |
| alloc_num_i | input | ALLOC_W+1 | Number of grants in the list |
| done_o | output | 1 | One-cycle scan completion pulse |
| instr_count_o | output | IMEM_AW+1 | Instructions written by the last scan |
| error_o | output | 1 | Unmergeable short leftover seen |
| alloc_addr_o | output | ALLOC_W | Grant list read index |
| alloc_id_i | input | ID_W | Grant traffic identifier |
| alloc_vol_i | input | VOL_W | Grant byte budget |
| alloc_scr_i | input | 1 | Grant scramble enable |
| lut_id_o | output | ID_W | Identifier to the queue lookup |
| lut_qsel_i | input | QSEL_W | Queue select from the lookup |
| fidx_qsel_o | output | QSEL_W | Frame index queue select |
| fidx_slot_o | output | SLOT_W | Frame index slot (queue head) |
| fidx_vld_i | input | 1 | Slot holds a frame |
| fidx_addr_i | input | ADDR_W | Frame start address |
| fidx_len_i | input | LEN_W | Frame length in bytes |
| imem_we_o | output | 1 | Instruction write enable |
| imem_addr_o | output | IMEM_AW | Instruction write address |
| imem_wdata_o | output | IW | Instruction word |

## Verification
Each grant costs three cycles, plus two for every frame taken, and `done_o` follows one cycle after the last grant. The bench derives that exact cycle from its own model of the grant list and counts falling edges from the `start_i` capture to match it. Instruction writes are combinational in the scan step that decides them. A monitor therefore compares every write at the falling edge of the same cycle against a queue of expected address/word pairs that the model pushed in program order. Merge rewrites appear as a second entry at an earlier address. Head persistence across scans is exercised by leaving frames unconsumed and granting the same queue again in a later scan.

// File: rtl/bws_pkg.sv
package bws_pkg;
  typedef enum logic [2:0] {S_IDLE, S_ALLOC, S_FRAME, S_DATA, S_GAP, S_FIN} scan_state_e;
  typedef enum logic [1:0] {K_HDR = 2'd0, K_DATA = 2'd1, K_IDLE = 2'd2} instr_kind_e;
endpackage

// File: rtl/bws_fit_calc.sv
module bws_fit_calc #(
  parameter int VOL_W     = 16,
  parameter int LEN_W     = 14,
  parameter int HDR_BYTES = 8
) (
  input  logic [VOL_W-1:0] rem_i,
  input  logic             vld_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             take_o,
  output logic [VOL_W-1:0] rem_after_o,
  output logic             gap_none_o,
  output logic             gap_full_o
);
  localparam int NW = VOL_W + 1;
  logic [NW-1:0] need;

  assign need        = NW'(len_i) + NW'(HDR_BYTES);
  assign take_o      = vld_i && (need <= {1'b0, rem_i});
  assign rem_after_o = rem_i - need[VOL_W-1:0];
  assign gap_none_o  = (rem_i == '0);
  assign gap_full_o  = (rem_i >= VOL_W'(HDR_BYTES));
endmodule

// File: rtl/bws_head_tbl.sv
module bws_head_tbl #(
  parameter int NQ     = 4,
  parameter int QSEL_W = 2,
  parameter int SLOT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [QSEL_W-1:0] sel_i,
  input  logic              adv_i,
  output logic [SLOT_W-1:0] head_o
);
  logic [SLOT_W-1:0] heads [NQ];

  for (genvar q = 0; q < NQ; q++) begin : g_head
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             heads[q] <= '0;
      else if (adv_i && sel_i == QSEL_W'(q))   heads[q] <= heads[q] + 1'b1;
    end
  end

  assign head_o = heads[sel_i];
endmodule

// File: rtl/bws_instr_fmt.sv
module bws_instr_fmt import bws_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int VOL_W  = 16,
  localparam int IW    = VOL_W + ADDR_W + 4
) (
  input  instr_kind_e       kind_i,
  input  logic              scr_i,
  input  logic              rep_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [VOL_W-1:0]  len_i,
  output logic [IW-1:0]     word_o
);
  assign word_o = {kind_i, scr_i, rep_i, addr_i, len_i};
endmodule

// File: rtl/bwmap_scanner.sv
module bwmap_scanner import bws_pkg::*; #(
  parameter int ID_W      = 12,
  parameter int NQ        = 4,
  parameter int SLOT_W    = 6,
  parameter int ALLOC_W   = 6,
  parameter int VOL_W     = 16,
  parameter int LEN_W     = 14,
  parameter int ADDR_W    = 16,
  parameter int IMEM_AW   = 8,
  parameter int HDR_BYTES = 8,
  localparam int QSEL_W   = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int IW       = VOL_W + ADDR_W + 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [ALLOC_W:0]   alloc_num_i,
  output logic               done_o,
  output logic [IMEM_AW:0]   instr_count_o,
  output logic               error_o,
  output logic [ALLOC_W-1:0] alloc_addr_o,
  input  logic [ID_W-1:0]    alloc_id_i,
  input  logic [VOL_W-1:0]   alloc_vol_i,
  input  logic               alloc_scr_i,
  output logic [ID_W-1:0]    lut_id_o,
  input  logic [QSEL_W-1:0]  lut_qsel_i,
  output logic [QSEL_W-1:0]  fidx_qsel_o,
  output logic [SLOT_W-1:0]  fidx_slot_o,
  input  logic               fidx_vld_i,
  input  logic [ADDR_W-1:0]  fidx_addr_i,
  input  logic [LEN_W-1:0]   fidx_len_i,
  output logic               imem_we_o,
  output logic [IMEM_AW-1:0] imem_addr_o,
  output logic [IW-1:0]      imem_wdata_o
);
  scan_state_e        state;
  logic [ALLOC_W-1:0] idx;
  logic [ALLOC_W:0]   nalloc;
  logic [QSEL_W-1:0]  cur_q;
  logic [VOL_W-1:0]   rem;
  logic               scr;
  logic [ADDR_W-1:0]  d_addr;
  logic [VOL_W-1:0]   d_len;
  logic [IMEM_AW:0]   icnt;
  logic               err;
  logic               has_idle;
  logic [IMEM_AW-1:0] li_addr;
  logic [VOL_W-1:0]   li_len;
  logic               li_scr;

  logic               take, gap_none, gap_full, last;
  logic [VOL_W-1:0]   rem_after;

  instr_kind_e        w_kind;
  logic               w_scr, w_rep;
  logic [ADDR_W-1:0]  w_addr;
  logic [VOL_W-1:0]   w_len;

  bws_fit_calc #(.VOL_W(VOL_W), .LEN_W(LEN_W), .HDR_BYTES(HDR_BYTES)) u_fit (
    .rem_i(rem), .vld_i(fidx_vld_i), .len_i(fidx_len_i),
    .take_o(take), .rem_after_o(rem_after),
    .gap_none_o(gap_none), .gap_full_o(gap_full)
  );

  bws_head_tbl #(.NQ(NQ), .QSEL_W(QSEL_W), .SLOT_W(SLOT_W)) u_head (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(cur_q),
    .adv_i(state == S_FRAME && take), .head_o(fidx_slot_o)
  );

  bws_instr_fmt #(.ADDR_W(ADDR_W), .VOL_W(VOL_W)) u_fmt (
    .kind_i(w_kind), .scr_i(w_scr), .rep_i(w_rep),
    .addr_i(w_addr), .len_i(w_len), .word_o(imem_wdata_o)
  );

  assign alloc_addr_o  = idx;
  assign lut_id_o      = alloc_id_i;
  assign fidx_qsel_o   = cur_q;
  assign done_o        = (state == S_FIN);
  assign instr_count_o = icnt;
  assign error_o       = err;
  assign last          = ({1'b0, idx} + 1'b1) == nalloc;

  always_comb begin
    imem_we_o   = 1'b0;
    imem_addr_o = icnt[IMEM_AW-1:0];
    w_kind      = K_HDR;
    w_scr       = scr;
    w_rep       = 1'b0;
    w_addr      = fidx_addr_i;
    w_len       = VOL_W'(HDR_BYTES);
    unique case (state)
      S_FRAME: imem_we_o = take;
      S_DATA: begin
        imem_we_o = 1'b1;
        w_kind    = K_DATA;
        w_addr    = d_addr;
        w_len     = d_len;
      end
      S_GAP: begin
        w_kind = K_IDLE;
        w_rep  = 1'b1;
        w_addr = '0;
        w_len  = rem;
        if (!gap_none) begin
          if (gap_full) begin
            imem_we_o = 1'b1;
          end else if (has_idle) begin
            // short leftover extends the last idle word in place
            imem_we_o   = 1'b1;
            imem_addr_o = li_addr;
            w_len       = li_len + rem;
            w_scr       = li_scr;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= S_IDLE;
      idx      <= '0;
      nalloc   <= '0;
      cur_q    <= '0;
      rem      <= '0;
      scr      <= 1'b0;
      d_addr   <= '0;
      d_len    <= '0;
      icnt     <= '0;
      err      <= 1'b0;
      has_idle <= 1'b0;
      li_addr  <= '0;
      li_len   <= '0;
      li_scr   <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (start_i) begin
          idx      <= '0;
          nalloc   <= alloc_num_i;
          icnt     <= '0;
          err      <= 1'b0;
          has_idle <= 1'b0;
          state    <= (alloc_num_i == '0) ? S_FIN : S_ALLOC;
        end
        S_ALLOC: begin
          cur_q <= lut_qsel_i;
          rem   <= alloc_vol_i;
          scr   <= alloc_scr_i;
          state <= S_FRAME;
        end
        S_FRAME: begin
          if (take) begin
            d_addr <= fidx_addr_i;
            d_len  <= VOL_W'(fidx_len_i);
            rem    <= rem_after;
            icnt   <= icnt + 1'b1;
            state  <= S_DATA;
          end else begin
            state  <= S_GAP;
          end
        end
        S_DATA: begin
          icnt  <= icnt + 1'b1;
          state <= S_FRAME;
        end
        S_GAP: begin
          if (!gap_none) begin
            if (gap_full) begin
              icnt     <= icnt + 1'b1;
              has_idle <= 1'b1;
              li_addr  <= icnt[IMEM_AW-1:0];
              li_len   <= rem;
              li_scr   <= scr;
            end else if (has_idle) begin
              li_len <= li_len + rem;
            end else begin
              err <= 1'b1;
            end
          end
          if (last) begin
            state <= S_FIN;
          end else begin
            idx   <= idx + 1'b1;
            state <= S_ALLOC;
          end
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bwmap_scanner_chk.sv
module bwmap_scanner_chk #(
  parameter int VOL_W     = 16,
  parameter int ADDR_W    = 16,
  parameter int IMEM_AW   = 8,
  parameter int HDR_BYTES = 8,
  localparam int IW       = VOL_W + ADDR_W + 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               done_o,
  input logic               error_o,
  input logic               imem_we_o,
  input logic [IMEM_AW-1:0] imem_addr_o,
  input logic [IW-1:0]      imem_wdata_o
);
  logic [1:0]       kind;
  logic             rep;
  logic [VOL_W-1:0] len;
  logic [ADDR_W-1:0] addr;

  assign kind = imem_wdata_o[IW-1 -: 2];
  assign rep  = imem_wdata_o[VOL_W + ADDR_W];
  assign addr = imem_wdata_o[VOL_W +: ADDR_W];
  assign len  = imem_wdata_o[VOL_W-1:0];

  // R3
  hdr_before_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imem_we_o && kind == 2'd1) |->
      ($past(imem_we_o) && $past(kind) == 2'd0 && imem_addr_o == $past(imem_addr_o) + 1'b1
       && addr == $past(addr)));

  // R3
  hdr_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imem_we_o && kind == 2'd0) |-> (len == VOL_W'(HDR_BYTES) && !rep));

  // R5
  idle_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imem_we_o && kind == 2'd2) |-> (len >= VOL_W'(HDR_BYTES) && rep && addr == '0));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !imem_we_o);

  // R7
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_o && !start_i) |=> error_o);
endmodule

bind bwmap_scanner bwmap_scanner_chk #(
  .VOL_W(VOL_W), .ADDR_W(ADDR_W), .IMEM_AW(IMEM_AW), .HDR_BYTES(HDR_BYTES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .done_o(done_o),
  .error_o(error_o), .imem_we_o(imem_we_o), .imem_addr_o(imem_addr_o),
  .imem_wdata_o(imem_wdata_o)
);

// File: tb/bwmap_scanner_tb.sv
`timescale 1ns/100ps
module bwmap_scanner_tb;
  localparam int ID_W = 12, NQ = 4, SLOT_W = 6, ALLOC_W = 6, VOL_W = 16, LEN_W = 14;
  localparam int ADDR_W = 16, IMEM_AW = 8, HDR = 8, QSEL_W = 2, IW = VOL_W + ADDR_W + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic               start;
  logic [ALLOC_W:0]   alloc_num;
  logic               done_o, error_o, fidx_vld, imem_we_o, alloc_scr;
  logic [IMEM_AW:0]   instr_count_o;
  logic [ALLOC_W-1:0] alloc_addr_o;
  logic [ID_W-1:0]    alloc_id, lut_id_o;
  logic [VOL_W-1:0]   alloc_vol;
  logic [QSEL_W-1:0]  lut_qsel, fidx_qsel_o;
  logic [SLOT_W-1:0]  fidx_slot_o;
  logic [ADDR_W-1:0]  fidx_addr;
  logic [LEN_W-1:0]   fidx_len;
  logic [IMEM_AW-1:0] imem_addr_o;
  logic [IW-1:0]      imem_wdata_o;

  // bench-side memories
  logic [ID_W-1:0]  al_id  [64];
  logic [VOL_W-1:0] al_vol [64];
  logic             al_scr [64];
  int               fq_len [NQ][8];
  int               fq_cnt [NQ];

  function automatic int lut_fn(logic [ID_W-1:0] id);
    case (id)
      12'h101: return 0;
      12'h2A2: return 1;
      12'h033: return 2;
      12'h7F4: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] fq_addr(int q, int s);
    return ADDR_W'(16'h1000 * (q + 1) + 16'h0100 * s);
  endfunction

  always_comb begin
    alloc_id  = al_id[alloc_addr_o];
    alloc_vol = al_vol[alloc_addr_o];
    alloc_scr = al_scr[alloc_addr_o];
    lut_qsel  = QSEL_W'(lut_fn(lut_id_o));
    fidx_vld  = int'(fidx_slot_o) < fq_cnt[fidx_qsel_o];
    fidx_addr = fq_addr(int'(fidx_qsel_o), int'(fidx_slot_o[2:0]));
    fidx_len  = LEN_W'(fq_len[fidx_qsel_o][fidx_slot_o[2:0]]);
  end

  bwmap_scanner u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .alloc_num_i(alloc_num),
    .done_o(done_o), .instr_count_o(instr_count_o), .error_o(error_o),
    .alloc_addr_o(alloc_addr_o), .alloc_id_i(alloc_id), .alloc_vol_i(alloc_vol),
    .alloc_scr_i(alloc_scr), .lut_id_o(lut_id_o), .lut_qsel_i(lut_qsel),
    .fidx_qsel_o(fidx_qsel_o), .fidx_slot_o(fidx_slot_o), .fidx_vld_i(fidx_vld),
    .fidx_addr_i(fidx_addr), .fidx_len_i(fidx_len), .imem_we_o(imem_we_o),
    .imem_addr_o(imem_addr_o), .imem_wdata_o(imem_wdata_o)
  );

  int n_run = 0, n_fail = 0;
  logic [IMEM_AW-1:0] exp_a [$];
  logic [IW-1:0]      exp_w [$];
  string              exp_t [$];

  // model state
  int mh [NQ] = '{0, 0, 0, 0};

  function automatic logic [IW-1:0] mk(int kind, bit scr, bit rep, int addr, int len);
    return {2'(kind), scr, rep, ADDR_W'(addr), VOL_W'(len)};
  endfunction

  task automatic push(int a, logic [IW-1:0] w, string t);
    exp_a.push_back(IMEM_AW'(a));
    exp_w.push_back(w);
    exp_t.push_back(t);
  endtask

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: compare every instruction write
  always @(negedge clk) begin
    if (rst_n && imem_we_o) begin
      n_run++;
      if (exp_a.size() == 0) begin
        n_fail++;
        $display("FAIL R3: unexpected write addr %0d word %h, expected none", imem_addr_o, imem_wdata_o);
      end else begin
        logic [IMEM_AW-1:0] ea;
        logic [IW-1:0] ew;
        string et;
        ea = exp_a.pop_front();
        ew = exp_w.pop_front();
        et = exp_t.pop_front();
        if (ea !== imem_addr_o || ew !== imem_wdata_o) begin
          n_fail++;
          $display("FAIL %s: actual addr %0d word %h, expected addr %0d word %h",
                   et, imem_addr_o, imem_wdata_o, ea, ew);
        end
      end
    end
  end

  // driver: model the grant list, push expected writes, run the scan
  task automatic run_scan(int n);
    int cyc = 1, cnt = 0, li_a = 0, li_l = 0, c;
    bit err = 0, has = 0, li_s = 0;
    for (int i = 0; i < n; i++) begin
      int q = lut_fn(al_id[i]);
      int rem = int'(al_vol[i]);
      bit s = al_scr[i];
      cyc += 3;
      while (mh[q] < fq_cnt[q] && fq_len[q][mh[q]] + HDR <= rem) begin
        int ln = fq_len[q][mh[q]];
        int ad = int'(fq_addr(q, mh[q]));
        push(cnt, mk(0, s, 0, ad, HDR), "R2/R3/R4/R8 header");
        push(cnt + 1, mk(1, s, 0, ad, ln), "R2/R3/R8 payload");
        cnt += 2;
        rem -= ln + HDR;
        mh[q]++;
        cyc += 2;
      end
      if (rem >= HDR) begin
        push(cnt, mk(2, s, 1, 0, rem), "R5/R8 idle");
        has = 1; li_a = cnt; li_l = rem; li_s = s;
        cnt++;
      end else if (rem > 0) begin
        if (has) begin
          li_l += rem;
          push(li_a, mk(2, li_s, 1, 0, li_l), "R6/R8 merge");
        end else begin
          err = 1;
        end
      end
    end
    @(negedge clk);
    start = 1'b1;
    alloc_num = (ALLOC_W + 1)'(n);
    @(negedge clk);
    start = 1'b0;
    c = 1;
    while (!done_o && c < 2000) begin
      @(negedge clk);
      c++;
    end
    check(c == cyc, "R9/R10 done cycle", c, cyc);
    check(int'(instr_count_o) == cnt, "R9 instr count", instr_count_o, cnt);
    check(error_o == err, "R7 error flag", error_o, err);
    check(exp_a.size() == 0, "R3 missing writes", exp_a.size(), 0);
    @(negedge clk);
    check(!done_o, "R9 done single pulse", done_o, 0);
    check(error_o == err, "R7 error held", error_o, err);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    start = 1'b0;
    alloc_num = '0;
    for (int i = 0; i < 64; i++) begin al_id[i] = '0; al_vol[i] = '0; al_scr[i] = 1'b0; end
    for (int q = 0; q < NQ; q++) for (int s = 0; s < 8; s++) fq_len[q][s] = 0;
    fq_cnt = '{3, 2, 1, 0};
    fq_len[0][0] = 40; fq_len[0][1] = 100; fq_len[0][2] = 20;
    fq_len[1][0] = 60; fq_len[1][1] = 60;
    fq_len[2][0] = 10;

    repeat (3) @(negedge clk);
    check(!done_o && !error_o && !imem_we_o && instr_count_o == 0, "R1 in reset",
          {done_o, error_o, imem_we_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!done_o && !error_o && !imem_we_o && instr_count_o == 0, "R1 after reset",
          {done_o, error_o, imem_we_o}, 0);

    // A: pack q0 fully with idle tail, short gap merged, exact fit on q1
    al_id[0] = 12'h101; al_vol[0] = 200; al_scr[0] = 1;
    al_id[1] = 12'h7F4; al_vol[1] = 5;   al_scr[1] = 0;
    al_id[2] = 12'h2A2; al_vol[2] = 68;  al_scr[2] = 0;
    run_scan(3);

    // B: oversize frame stays queued, later taken; merge; zero budget
    al_id[0] = 12'h2A2; al_vol[0] = 50; al_scr[0] = 0;
    al_id[1] = 12'h2A2; al_vol[1] = 70; al_scr[1] = 1;
    al_id[2] = 12'h101; al_vol[2] = 0;  al_scr[2] = 1;
    run_scan(3);

    // C: short leftover with no idle word yet -> error
    al_id[0] = 12'h033; al_vol[0] = 20; al_scr[0] = 1;
    run_scan(1);

    // D: empty list clears the error
    run_scan(0);

    // E: idle exactly header size, merge, plain idle
    al_id[0] = 12'h101; al_vol[0] = 8; al_scr[0] = 1;
    al_id[1] = 12'h7F4; al_vol[1] = 7; al_scr[1] = 0;
    al_id[2] = 12'h033; al_vol[2] = 9; al_scr[2] = 0;
    run_scan(3);

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule